// File: doc/BRIEF.md
# Backlight PWM Duty-to-Level Readback

This block recovers a 16-bit brightness level from the settings that drive a backlight PWM generator. The settings are a period value, a period-width field, an active (high-time) count and a flag that selects fractional active counts. The block treats the active count as a fraction of the period and scales that fraction to the full level range. The result is rounded to the nearest integer.

A one-cycle start pulse captures the settings. The block masks each field to its valid width and builds a dividend with one extra bit of precision. A restoring divider then retires one quotient bit per clock. The quotient is rounded and clamped, and the level is presented with a one-cycle done strobe. The level output holds its value until the next result is ready. While a division is in progress, further start pulses are ignored.

The active count is aligned to the most significant end of its field, and the number of valid bits follows the period-width field. The result therefore reads as a normalised duty value no matter how many bits the period uses.

Top module: `pwm_level_readback`

## Requirements
- R1: The effective period width n equals the value of the width field `bitcnt_i`, except that a field value of 0 means n = W (16 by default).
- R2: Only the low n bits of `period_i` are used; any higher bits have no effect on the level.
- R3: With `frac_en_i` low, only the top n bits of `active_i` are used (bits W-1 down to W-n), and the lower bits have no effect. With `frac_en_i` high, all W bits of `active_i` are used.
- R4: A masked period of zero is replaced by the all-ones value (0xFFFF by default) before the division.
- R5: The level is (q + 1) >> 1, where q = floor((A << (n+1)) / P), A is the masked active count and P is the effective period. This gives A·2^n/P rounded to nearest, with halves rounding up.
- R6: A rounded level above the all-ones value is reported as all-ones (0xFFFF) and does not wrap.
- R7: A start pulse while `busy_o` is high is ignored. The running division keeps the settings captured at its own start and produces exactly one result.
- R8: After a start is accepted, `busy_o` is high from the next cycle until the division ends. `done_o` is high for exactly one cycle, 2·W+2 rising edges after the accepting edge, with the new level on `level_o`. `level_o` holds its value at all other times.
- R9: After reset, `level_o` is 0 and `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the settings when idle |
| period_i | input | W | PWM period value |
| bitcnt_i | input | log2(W) | Effective period width; 0 means W |
| active_i | input | W | Active count, MSB-aligned |
| frac_en_i | input | 1 | Keep all active-count bits when high |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| level_o | output | W | Rounded, clamped brightness level |

## Verification
The bench builds the block with W = 16 and the clamping variant selected. This makes every width-field code reachable, from 1 to 15 plus the zero code that aliases to 16, and it gives the full 33-step division. At this width, a maximal active count over a one-count period is enough to reach the clamp. A small period with chosen active counts reaches both rounding directions (a remainder just below and just above one half).

// File: rtl/pbr_pkg.sv
package pbr_pkg;

   // Effective period width: a zero field selects the full width.
   function automatic int eff_width(input int field_val, input int full_w);
      return (field_val == 0) ? full_w : field_val;
   endfunction

endpackage

// File: rtl/pbr_prep.sv
module pbr_prep
   import pbr_pkg::*;
#(
   parameter int W  = 16,
   parameter int CW = $clog2(W),
   parameter int DW = 2 * W + 1
) (
   input  logic [W-1:0]  period_i,
   input  logic [CW-1:0] bitcnt_i,
   input  logic [W-1:0]  active_i,
   input  logic          frac_en_i,
   output logic [DW-1:0] dividend_o,
   output logic [W-1:0]  divisor_o
);

   int          n_eff;
   logic [W-1:0] low_mask;
   logic [W-1:0] act_mask;
   logic [W-1:0] per_m;
   logic [W-1:0] act_m;

   always_comb begin
      n_eff    = eff_width(int'(bitcnt_i), W);
      low_mask = {W{1'b1}} >> (W - n_eff);
      per_m    = period_i & low_mask;
      act_mask = frac_en_i ? {W{1'b1}} : (low_mask << (W - n_eff));
      act_m    = active_i & act_mask;
      divisor_o  = (per_m == '0) ? {W{1'b1}} : per_m;
      dividend_o = DW'(act_m) << (n_eff + 1);
   end

endmodule

// File: rtl/pbr_divider.sv
module pbr_divider #(
   parameter int W    = 16,
   parameter int DW   = 2 * W + 1,
   parameter int CNTW = $clog2(DW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] dividend_i,
   input  logic [W-1:0]  divisor_i,
   output logic          busy_o,
   output logic          fin_o,
   output logic [DW-1:0] quo_o
);

   localparam logic [CNTW-1:0] LAST = CNTW'(DW - 1);

   logic [DW-1:0]   quo_q;
   logic [W-1:0]    rem_q;
   logic [W-1:0]    dvs_q;
   logic [CNTW-1:0] cnt_q;
   logic            busy_q;
   logic            fin_q;

   logic [W:0]      trial;
   logic [W:0]      diff;
   logic            fits;

   always_comb begin
      trial = {rem_q, quo_q[DW-1]};
      fits  = (trial >= {1'b0, dvs_q});
      diff  = trial - {1'b0, dvs_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (busy_q) begin
            quo_q <= {quo_q[DW-2:0], fits};
            rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               fin_q  <= 1'b1;
            end
         end else if (load_i) begin
            quo_q  <= dividend_i;
            rem_q  <= '0;
            dvs_q  <= divisor_i;
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign fin_o  = fin_q;
   assign quo_o  = quo_q;

   // R5
   rem_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (rem_q < dvs_q));

   // R7
   hold_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && load_i) |=> $stable(dvs_q));

   // R8
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= LAST));

endmodule

// File: rtl/pbr_round.sv
module pbr_round #(
   parameter int W        = 16,
   parameter int DW       = 2 * W + 1,
   parameter bit SATURATE = 1'b1
) (
   input  logic [DW-1:0] quo_i,
   output logic [W-1:0]  level_o
);

   logic [DW:0]   sum;
   logic [DW-1:0] half;

   always_comb begin
      sum  = {1'b0, quo_i} + 1'b1;
      half = sum[DW:1];
   end

   generate
      if (SATURATE) begin : g_clamp
         assign level_o = (|half[DW-1:W]) ? {W{1'b1}} : half[W-1:0];
      end else begin : g_wrap
         assign level_o = half[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/pwm_level_readback.sv
module pwm_level_readback #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1,
   parameter int CW       = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [W-1:0]  period_i,
   input  logic [CW-1:0] bitcnt_i,
   input  logic [W-1:0]  active_i,
   input  logic          frac_en_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [W-1:0]  level_o
);

   localparam int DW = 2 * W + 1;

   initial begin
      width_param_chk: assert (W >= 4 && (1 << CW) == W)
         else $error("W must be a power of two of at least 4");
   end

   logic [DW-1:0] dividend;
   logic [W-1:0]  divisor;
   logic [DW-1:0] quo;
   logic [W-1:0]  rounded;
   logic          div_fin;
   logic          div_busy;
   logic [W-1:0]  level_q;
   logic          done_q;

   pbr_prep #(.W(W), .CW(CW), .DW(DW)) u_prep (
      .period_i  (period_i),
      .bitcnt_i  (bitcnt_i),
      .active_i  (active_i),
      .frac_en_i (frac_en_i),
      .dividend_o(dividend),
      .divisor_o (divisor)
   );

   pbr_divider #(.W(W), .DW(DW)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_i),
      .dividend_i(dividend),
      .divisor_i (divisor),
      .busy_o    (div_busy),
      .fin_o     (div_fin),
      .quo_o     (quo)
   );

   pbr_round #(.W(W), .DW(DW), .SATURATE(SATURATE)) u_round (
      .quo_i  (quo),
      .level_o(rounded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= div_fin;
         if (div_fin) begin
            level_q <= rounded;
         end
      end
   end

   assign busy_o  = div_busy;
   assign done_o  = done_q;
   assign level_o = level_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_fin |=> $stable(level_o));

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(div_busy) |=> done_o);

endmodule

// File: tb/pwm_level_readback_test.sv
module pwm_level_readback_test;

   localparam int W      = 16;
   localparam int CLK_PD = 10;
   localparam int LAT    = 2 * W + 3;  // negedges counted from the one after the accepting edge
   localparam int NV     = 11;

   // {period, bitcnt, active, frac, expected level}
   localparam logic [52:0] VEC [NV] = '{
      {16'hFFFF, 4'd0,  16'h8000, 1'b0, 16'h8001},  // R1 zero width code -> 16
      {16'h00FF, 4'd8,  16'h8000, 1'b0, 16'h8081},  // R5 half duty, 8-bit period
      {16'h12FF, 4'd8,  16'h8000, 1'b0, 16'h8081},  // R2 upper period bits ignored
      {16'h00FF, 4'd8,  16'h80FF, 1'b0, 16'h8081},  // R3 low active bits masked
      {16'h00FF, 4'd8,  16'h80FF, 1'b1, 16'h8181},  // R3 fractional bits kept
      {16'h00F0, 4'd4,  16'hF000, 1'b0, 16'h000F},  // R4 zero period -> all ones
      {16'h0001, 4'd4,  16'hF000, 1'b0, 16'hFFFF},  // R6 clamp
      {16'h0003, 4'd2,  16'h4000, 1'b0, 16'h5555},  // R5 rounds down
      {16'h0003, 4'd2,  16'h8000, 1'b0, 16'hAAAB},  // R5 rounds up
      {16'h7FFF, 4'd15, 16'h7FFE, 1'b0, 16'h7FFF},  // R5 wide period
      {16'h0005, 4'd3,  16'h0000, 1'b1, 16'h0000}   // R5 zero active
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  period_v = '0;
   logic [3:0]    bitcnt_v = '0;
   logic [W-1:0]  active_v = '0;
   logic          frac_v = 1'b0;
   logic          busy;
   logic          done;
   logic [W-1:0]  level;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PD / 2) clk = ~clk;

   pwm_level_readback #(.W(W), .SATURATE(1'b1)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .period_i (period_v),
      .bitcnt_i (bitcnt_v),
      .active_i (active_v),
      .frac_en_i(frac_v),
      .busy_o   (busy),
      .done_o   (done),
      .level_o  (level)
   );

   function automatic string tag_of(input int i);
      case (i)
         0: return "R1";
         2: return "R2";
         3, 4: return "R3";
         5: return "R4";
         6: return "R6";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int got, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic run(input logic [W-1:0] per, input logic [3:0] bc,
                      input logic [W-1:0] act, input logic fr,
                      output logic [W-1:0] lvl, output int lat);
      @(negedge clk);
      period_v = per;
      bitcnt_v = bc;
      active_v = act;
      frac_v   = fr;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      lvl = level;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] lvl;
      int lat;
      int pulses;

      repeat (3) @(negedge clk);
      // R9 reset state
      check(level == '0, "R9", "level after reset", int'(level), 0);
      check(done == 1'b0, "R9", "done after reset", int'(done), 0);
      check(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run(VEC[i][52:37], VEC[i][36:33], VEC[i][32:17], VEC[i][16], lvl, lat);
         check(lvl == VEC[i][15:0], tag_of(i), "level", int'(lvl), int'(VEC[i][15:0]));
         check(lat == LAT, "R8", "latency", lat, LAT);
         @(negedge clk);
         check(done == 1'b0, "R8", "done width", int'(done), 0);
         check(level == lvl, "R8", "level hold", int'(level), int'(lvl));
      end

      // R7: second start during a running division is ignored
      @(negedge clk);
      period_v = 16'h00FF; bitcnt_v = 4'd8; active_v = 16'h8000; frac_v = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
      lat = 1;
      repeat (4) begin
         @(negedge clk);
         lat++;
      end
      period_v = 16'h0003; bitcnt_v = 4'd2; active_v = 16'h4000;
      start = 1'b1;
      @(negedge clk);
      lat++;
      start = 1'b0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      check(level == 16'h8081, "R7", "level keeps first settings", int'(level), 16'h8081);
      check(lat == LAT, "R7", "latency unchanged", lat, LAT);
      pulses = 0;
      repeat (2 * LAT) begin
         @(negedge clk);
         if (done) pulses++;
      end
      check(pulses == 0, "R7", "extra done pulses", pulses, 0);
      check(busy == 1'b0, "R7", "idle after ignored start", int'(busy), 0);
      check(level == 16'h8081, "R7", "level after ignored start", int'(level), 16'h8081);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule